// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits behind a memory-mapped slave port with a 64-bit data path and two dword lane enables. It fronts a bank of 128-bit device registers, a table of 32-bit direct registers and a small 64-bit SRAM. The host can only move 32 or 64 bits per access, but every 128-bit register must change in a single step. The collector therefore parks the lower three dwords in a staging buffer. The write that carries dword 3 then lands all 128 bits in one cycle.

Reads of a wide register work the other way round. Reading dword 0 takes a full 128-bit snapshot of the register, and the other dwords are then returned from that snapshot, so the host sees one consistent value. Direct registers bypass the collector: they take effect on their own single write and leave any staged data untouched. SRAM entries are built from a low half followed by a high half.

The address space is split into pages spaced 0x2000 bytes apart. Register tables inside a page use a 16-byte stride.

Top module: `wide_reg_collector`

## Requirements
- R1: While `rst_n` is low at a clock edge, `req_ready`, `rsp_valid` and `tag_mismatch` go low and all storage clears. From the first edge after reset is released, `req_ready` is high. A register read before any write returns zero.
- R2: Bit 15 of the byte address selects SRAM, with the entry index in bits 14:3 (8-byte stride). Otherwise bits 14:13 give the page (0x2000 stride), bit 12 selects the direct table, bits 11:4 give the table index (16-byte stride), and bit 3 gives the quad within a wide register. Bits 2:0 are ignored. Pages and indices are independent storage. Locations outside the parameter ranges read as zero and ignore writes.
- R3: Lane 0 (`req_be[0]`, data bits 31:0) and lane 1 (`req_be[1]`, data bits 63:32) carry the lower and upper dword of the addressed quad. A wide register stays unchanged through writes of dwords 0, 1 and 2. The write of dword 3 (quad 1, lane 1) updates all 128 bits at once.
- R4: Two 64-bit writes (both lanes) to quad 0 and then quad 1 produce the same result as four single-dword writes.
- R5: A read of quad 0 with lane 0 enabled returns the live low 64 bits and copies the whole register into the shadow. A following read of quad 1 returns the shadow contents, even if the register was rewritten in between.
- R6: A wide read that does not include dword 0 returns the shadow contents left by the most recent dword 0 read, whichever register that was. Reads always return both lanes.
- R7: A lane-0 write to a direct register at quad 0 takes effect at once and reads back in bits 31:0, with bits 63:32 reading zero. Such a write leaves staged wide data and `tag_mismatch` unchanged.
- R8: An SRAM write with only lane 0 enabled holds the low half and leaves the entry unchanged. A write with lane 1 enabled commits the entry, taking the low half from lane 0 if that lane is enabled and from the held value otherwise.
- R9: A dword 3 write whose register (page and index) differs from the register of the last staging write still commits. It writes its own data together with the staged dwords into its own target, and it sets `tag_mismatch`, which stays set until reset.
- R10: Every accepted request completes in its acceptance cycle. `rsp_valid` is high exactly in the cycle after an accepted read and never after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_be | input | 2 | Dword lane enables |
| req_wdata | input | 64 | Write data, lane 0 in bits 31:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| tag_mismatch | output | 1 | Sticky: dword 3 hit a register other than the staged one |

## Verification
The bench interleaves direct-register writes into the middle of a wide collection. A collector that let them touch the staging buffer would commit corrupted lower dwords. It rewrites a register between the dword 0 and dword 1 reads, which exposes a design that serves upper dwords from the live register instead of the snapshot. It also reads upper dwords with no fresh dword 0 read, commits an SRAM entry in halves and in one piece, and finishes a collection on the wrong register. The last case catches a collector that drops the commit, writes the staged register, or never raises the sticky flag.

// File: rtl/wrc_pkg.sv
// Shared types for the wide register write collector.
// Assumes every slot count fits in SLOT_W bits.
package wrc_pkg;
    localparam int SLOT_W = 8;
    localparam int DW     = 32;

    typedef enum logic [1:0] {
        RGN_WIDE   = 2'd0,
        RGN_DIRECT = 2'd1,
        RGN_SRAM   = 2'd2,
        RGN_NONE   = 2'd3
    } region_e;

    typedef struct packed {
        region_e             rgn;
        logic [SLOT_W-1:0]   slot;
        logic                quad;
    } target_t;
endpackage

// File: rtl/wrc_decode.sv
// Address decoder: maps a byte address onto a storage region, a flat
// slot number (page folded in) and the quad within a wide register.
// Assumes ADDR_W is 16 so that bit 15 selects SRAM and bits 14:13 the page.
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_PAGES  = 2,
    parameter int NUM_WIDE   = 4,
    parameter int NUM_DIRECT = 3,
    parameter int NUM_SRAM   = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output target_t           tgt
);
    localparam int PAGE_LSB   = 13;
    localparam int DIRECT_BIT = 12;
    localparam int SRAM_BIT   = ADDR_W - 1;
    localparam int TBL_LSB    = 4;
    localparam int SRAM_LSB   = 3;

    // Split the address into fields and range-check each table.
    always_comb begin
        int unsigned pg, ti, si;
        pg = 32'(addr[SRAM_BIT-1:PAGE_LSB]);
        ti = 32'(addr[DIRECT_BIT-1:TBL_LSB]);
        si = 32'(addr[SRAM_BIT-1:SRAM_LSB]);
        tgt.quad = addr[3];
        tgt.rgn  = RGN_NONE;
        tgt.slot = '0;
        if (addr[SRAM_BIT]) begin
            if (si < NUM_SRAM) begin
                tgt.rgn  = RGN_SRAM;
                tgt.slot = SLOT_W'(si);
            end
        end else if (pg < NUM_PAGES) begin
            if (addr[DIRECT_BIT]) begin
                if (ti < NUM_DIRECT && !addr[3]) begin
                    tgt.rgn  = RGN_DIRECT;
                    tgt.slot = SLOT_W'(pg * NUM_DIRECT + ti);
                end
            end else if (ti < NUM_WIDE) begin
                tgt.rgn  = RGN_WIDE;
                tgt.slot = SLOT_W'(pg * NUM_WIDE + ti);
            end
        end
    end
endmodule

// File: rtl/wrc_stage.sv
// Staging buffer for 128-bit writes: holds dwords 0..2 and the slot of
// the last staging write, builds the full commit word when dword 3
// arrives and raises a sticky flag when dword 3 targets another slot.
// Assumes wr_en is only asserted for accepted wide-region writes.
module wrc_stage
    import wrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic              quad,
    input  logic [1:0]        be,
    input  logic [2*DW-1:0]   wdata,
    output logic              commit_en,
    output logic [SLOT_W-1:0] commit_slot,
    output logic [4*DW-1:0]   commit_data,
    output logic              tag_mismatch
);
    logic [3*DW-1:0]   held;
    logic [SLOT_W-1:0] held_slot;
    logic              mism_q;
    logic              stage_en;

    assign stage_en    = wr_en & ~(quad & be[1]);
    assign commit_en   = wr_en & quad & be[1];
    assign commit_slot = slot;
    assign commit_data = {wdata[2*DW-1:DW],
                          be[0] ? wdata[DW-1:0] : held[3*DW-1:2*DW],
                          held[2*DW-1:0]};
    assign tag_mismatch = mism_q;

    // Capture lower dwords and remember which register they belong to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= '0;
            held_slot <= '0;
        end else if (stage_en) begin
            if (!quad) begin
                if (be[0]) held[DW-1:0]    <= wdata[DW-1:0];
                if (be[1]) held[2*DW-1:DW] <= wdata[2*DW-1:DW];
            end else if (be[0]) begin
                held[3*DW-1:2*DW] <= wdata[DW-1:0];
            end
            held_slot <= slot;
        end
    end

    // Sticky flag for a commit that lands on a different register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               mism_q <= 1'b0;
        else if (commit_en && slot != held_slot)  mism_q <= 1'b1;
    end

    AST_STAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(held)); // R7
    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tag_mismatch |=> tag_mismatch); // R9
endmodule

// File: rtl/wrc_regfile.sv
// Register file model: wide registers, direct dword registers, SRAM
// entries with a low-half holding register, the 128-bit read shadow
// and the registered read response.
// Assumes slots from the decoder are in range for their region.
module wrc_regfile
    import wrc_pkg::*;
#(
    parameter int NUM_PAGES  = 2,
    parameter int NUM_WIDE   = 4,
    parameter int NUM_DIRECT = 3,
    parameter int NUM_SRAM   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_en,
    input  logic [SLOT_W-1:0] commit_slot,
    input  logic [4*DW-1:0]   commit_data,
    input  logic              dir_we,
    input  logic              sram_we,
    input  logic              rd_en,
    input  target_t           tgt,
    input  logic [1:0]        be,
    input  logic [2*DW-1:0]   wdata,
    output logic              rsp_valid,
    output logic [2*DW-1:0]   rsp_rdata
);
    localparam int WIDE_N = NUM_PAGES * NUM_WIDE;
    localparam int DIR_N  = NUM_PAGES * NUM_DIRECT;
    localparam int WIW    = (WIDE_N   > 1) ? $clog2(WIDE_N)   : 1;
    localparam int DIW    = (DIR_N    > 1) ? $clog2(DIR_N)    : 1;
    localparam int SIW    = (NUM_SRAM > 1) ? $clog2(NUM_SRAM) : 1;

    logic [4*DW-1:0] wide_q [WIDE_N];
    logic [DW-1:0]   dir_q  [DIR_N];
    logic [2*DW-1:0] sram_q [NUM_SRAM];
    logic [DW-1:0]   sram_lo;
    logic [4*DW-1:0] shadow;

    logic [WIW-1:0] ci, wi;
    logic [DIW-1:0] di;
    logic [SIW-1:0] si;
    assign ci = commit_slot[WIW-1:0];
    assign wi = tgt.slot[WIW-1:0];
    assign di = tgt.slot[DIW-1:0];
    assign si = tgt.slot[SIW-1:0];

    // Wide registers change only on a full 128-bit commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WIDE_N; k++) wide_q[k] <= '0;
        end else if (commit_en) begin
            wide_q[ci] <= commit_data;
        end
    end

    // Direct registers take a single dword immediately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DIR_N; k++) dir_q[k] <= '0;
        end else if (dir_we) begin
            dir_q[di] <= wdata[DW-1:0];
        end
    end

    // SRAM: hold a lone low half, commit the entry on the high half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SRAM; k++) sram_q[k] <= '0;
            sram_lo <= '0;
        end else if (sram_we) begin
            if (be[1])
                sram_q[si] <= {wdata[2*DW-1:DW], be[0] ? wdata[DW-1:0] : sram_lo};
            else if (be[0])
                sram_lo <= wdata[DW-1:0];
        end
    end

    // Read path: dword 0 reads load the shadow, others are served from it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            shadow    <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                case (tgt.rgn)
                    RGN_WIDE: begin
                        if (!tgt.quad && be[0]) begin
                            rsp_rdata <= wide_q[wi][2*DW-1:0];
                            shadow    <= wide_q[wi];
                        end else begin
                            rsp_rdata <= tgt.quad ? shadow[4*DW-1:2*DW] : shadow[2*DW-1:0];
                        end
                    end
                    RGN_DIRECT: rsp_rdata <= {{DW{1'b0}}, dir_q[di]};
                    RGN_SRAM:   rsp_rdata <= sram_q[si];
                    default:    rsp_rdata <= '0;
                endcase
            end
        end
    end

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid); // R10
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid); // R10
    AST_SNAPSHOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && tgt.rgn == RGN_WIDE && !tgt.quad && be[0])
        |=> (rsp_rdata == shadow[2*DW-1:0])); // R5
endmodule

// File: rtl/wide_reg_collector.sv
// Top level: single-cycle slave port in front of the decoder, the
// 128-bit staging buffer and the register file model.
// Assumes one request per cycle; read data follows one cycle later.
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_PAGES  = 2,
    parameter int NUM_WIDE   = 4,
    parameter int NUM_DIRECT = 3,
    parameter int NUM_SRAM   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [2*DW-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [2*DW-1:0]   rsp_rdata,
    output logic              tag_mismatch
);
    target_t           tgt;
    logic              ready_q, accept, wr_acc, rd_en;
    logic              wide_we, dir_we, sram_we;
    logic              commit_en;
    logic [SLOT_W-1:0] commit_slot;
    logic [4*DW-1:0]   commit_data;

    // Port is ready from the first cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign req_ready = ready_q;
    assign accept    = req_valid & ready_q;
    assign wr_acc    = accept & req_write;
    assign rd_en     = accept & ~req_write;
    assign wide_we   = wr_acc & (tgt.rgn == RGN_WIDE);
    assign dir_we    = wr_acc & (tgt.rgn == RGN_DIRECT) & req_be[0];
    assign sram_we   = wr_acc & (tgt.rgn == RGN_SRAM);

    wrc_decode #(
        .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .NUM_WIDE(NUM_WIDE),
        .NUM_DIRECT(NUM_DIRECT), .NUM_SRAM(NUM_SRAM)
    ) u_decode (
        .addr (req_addr),
        .tgt  (tgt)
    );

    wrc_stage u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wide_we),
        .slot         (tgt.slot),
        .quad         (tgt.quad),
        .be           (req_be),
        .wdata        (req_wdata),
        .commit_en    (commit_en),
        .commit_slot  (commit_slot),
        .commit_data  (commit_data),
        .tag_mismatch (tag_mismatch)
    );

    wrc_regfile #(
        .NUM_PAGES(NUM_PAGES), .NUM_WIDE(NUM_WIDE),
        .NUM_DIRECT(NUM_DIRECT), .NUM_SRAM(NUM_SRAM)
    ) u_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_en   (commit_en),
        .commit_slot (commit_slot),
        .commit_data (commit_data),
        .dir_we      (dir_we),
        .sram_we     (sram_we),
        .rd_en       (rd_en),
        .tgt         (tgt),
        .be          (req_be),
        .wdata       (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    AST_DIRECT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> $stable(tag_mismatch)); // R7
endmodule

// File: tb/test_wide_reg_collector.sv
module test_wide_reg_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        tag_mismatch;

    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    wide_reg_collector i_wide_reg_collector (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .tag_mismatch(tag_mismatch)
    );

    function automatic logic [15:0] wa(int p, int i, int q);
        return 16'(p * 16'h2000 + i * 16 + q * 8);
    endfunction
    function automatic logic [15:0] da(int p, int j);
        return 16'(p * 16'h2000 + 16'h1000 + j * 16);
    endfunction
    function automatic logic [15:0] sa(int k);
        return 16'(16'h8000 + k * 8);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one accepted request per call; called at posedge + 1.
    task automatic access(logic w, logic [15:0] a, logic [1:0] b, logic [63:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_be = b; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask
    task automatic wr(logic [15:0] a, logic [1:0] b, logic [63:0] d);
        access(1'b1, a, b, d);
    endtask
    task automatic rd(logic [15:0] a, logic [1:0] b, logic [63:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, a, b, 64'h0);
    endtask

    // Monitor: pop the scoreboard on each response, flag stray ones (R10).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R10: stray response actual %h expected none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 ready in reset", 64'(req_ready), 64'd0);
        check("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R1 mismatch in reset", 64'(tag_mismatch), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        rd(wa(0, 1, 0), 2'b11, 64'h0, "R1 wide reads zero");

        // R3: four single-dword writes, nothing visible before dword 3
        wr(wa(0, 1, 0), 2'b01, 64'h0000_0000_A000_0000);
        wr(wa(0, 1, 0), 2'b10, 64'hA111_1111_0000_0000);
        wr(wa(0, 1, 1), 2'b01, 64'h0000_0000_A222_2222);
        rd(wa(0, 1, 0), 2'b11, 64'h0, "R3 no partial update");
        wr(wa(0, 1, 1), 2'b10, 64'hA333_3333_0000_0000);
        rd(wa(0, 1, 0), 2'b11, 64'hA111_1111_A000_0000, "R3 low quad");
        rd(wa(0, 1, 1), 2'b11, 64'hA333_3333_A222_2222, "R3 high quad");

        // R4 and R2: 64-bit writes on page 1; page 0 same index untouched
        wr(wa(1, 2, 0), 2'b11, 64'hB111_1111_B000_0000);
        wr(wa(1, 2, 1), 2'b11, 64'hB333_3333_B222_2222);
        rd(wa(1, 2, 0), 2'b11, 64'hB111_1111_B000_0000, "R4 low quad");
        rd(wa(1, 2, 1), 2'b11, 64'hB333_3333_B222_2222, "R4 high quad");
        rd(wa(0, 2, 0), 2'b11, 64'h0, "R2 pages are separate");

        // R5: snapshot survives a rewrite of the live register
        rd(wa(1, 2, 0), 2'b11, 64'hB111_1111_B000_0000, "R5 snapshot load");
        wr(wa(1, 2, 0), 2'b11, 64'hC111_1111_C000_0000);
        wr(wa(1, 2, 1), 2'b11, 64'hC333_3333_C222_2222);
        rd(wa(1, 2, 1), 2'b11, 64'hB333_3333_B222_2222, "R5 served from shadow");
        rd(wa(1, 2, 0), 2'b11, 64'hC111_1111_C000_0000, "R5 fresh low quad");
        rd(wa(1, 2, 1), 2'b11, 64'hC333_3333_C222_2222, "R5 fresh high quad");

        // R6: upper read of another register with no dword 0 read
        rd(wa(0, 1, 1), 2'b11, 64'hC333_3333_C222_2222, "R6 stale shadow");

        // R7: direct writes interleaved into a collection
        wr(wa(0, 3, 0), 2'b11, 64'hD111_1111_D000_0000);
        wr(da(0, 1), 2'b01, 64'h0000_0000_E000_000E);
        wr(wa(0, 3, 1), 2'b01, 64'h0000_0000_D222_2222);
        wr(da(1, 2), 2'b01, 64'h0000_0000_F000_000F);
        wr(wa(0, 3, 1), 2'b10, 64'hD333_3333_0000_0000);
        rd(da(0, 1), 2'b01, 64'h0000_0000_E000_000E, "R7 direct page 0");
        rd(da(1, 2), 2'b01, 64'h0000_0000_F000_000F, "R7 direct page 1");
        rd(wa(0, 3, 0), 2'b11, 64'hD111_1111_D000_0000, "R7 staging intact low");
        rd(wa(0, 3, 1), 2'b11, 64'hD333_3333_D222_2222, "R7 staging intact high");
        check("R9 no mismatch on clean commits", 64'(tag_mismatch), 64'd0);

        // R8: SRAM in halves and in one access
        wr(sa(5), 2'b01, 64'h0000_0000_6000_0006);
        rd(sa(5), 2'b11, 64'h0, "R8 low half alone");
        wr(sa(5), 2'b10, 64'h6111_1116_0000_0000);
        rd(sa(5), 2'b11, 64'h6111_1116_6000_0006, "R8 halves commit");
        wr(sa(2), 2'b11, 64'h7111_1117_7000_0007);
        rd(sa(2), 2'b11, 64'h7111_1117_7000_0007, "R8 single write");

        // R9: dword 3 lands on a different register than the staged one
        wr(wa(0, 0, 0), 2'b11, 64'h9111_1111_9000_0000);
        wr(wa(0, 0, 1), 2'b01, 64'h0000_0000_9222_2222);
        wr(wa(1, 0, 1), 2'b10, 64'h9333_3333_0000_0000);
        check("R9 flag set", 64'(tag_mismatch), 64'd1);
        rd(wa(1, 0, 0), 2'b11, 64'h9111_1111_9000_0000, "R9 commit low");
        rd(wa(1, 0, 1), 2'b11, 64'h9333_3333_9222_2222, "R9 commit high");
        rd(wa(0, 0, 0), 2'b11, 64'h0, "R9 staged target untouched");
        wr(wa(0, 2, 0), 2'b11, 64'h1);
        wr(wa(0, 2, 1), 2'b11, 64'h2);
        check("R9 flag sticky", 64'(tag_mismatch), 64'd1);

        // R10: all reads answered, nothing outstanding
        repeat (3) @(posedge clk);
        #1;
        check("R10 responses drained", 64'(exp_q.size()), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule